// File: doc/BRIEF.md
# Fractional Pulse-Rate Divider

This block turns a fast base clock into a stream of single-cycle enable ticks whose average spacing is N + b/a base cycles. N is the integer part of the ratio. The fraction b/a has a denominator of at most 63. The fraction is realised by mixing periods of N and N+1 cycles. An error accumulator decides which periods get the extra cycle. A pattern generator uses the ticks to step a serial or parallel pulse stream at a fixed symbol rate.

Settings arrive on a load strobe and wait in a pending register. When the divider is idle they are applied at once. When it is running they are applied only at the next period boundary, so a period is never cut short or lengthened midway. The fractional sequence restarts from zero each time a new setting is applied. Out-of-range settings are forced into range:
- an integer part below the minimum of 4 is raised to 4, which caps the tick rate at a quarter of the base clock;
- a zero denominator becomes 1;
- a numerator that is not smaller than the denominator becomes denominator minus one.

Top module: `frac_tick_div`

## Requirements
- R1: `tick` is high for exactly one base-clock cycle per period, and never in two consecutive cycles.
- R2: With a numerator of 0, every period lasts exactly N cycles. For example, N=10 gives a tick every 10 cycles, which is 8 MHz from an 80 MHz base.
- R3: Periods are counted k = 1, 2, … from the start of a run or from the application of a setting. Period k lasts N+1 cycles when floor(k·b/a) > floor((k−1)·b/a), and N cycles otherwise. Any a consecutive periods therefore contain exactly b long ones.
- R4: While `run` is low, no tick is produced and the period counter and accumulator are held at zero. After `run` goes high, the first tick is high after the k-th rising edge at which `run` is sampled high, where k is the length of the first period.
- R5: A setting loaded while running does not change the period in progress. It takes effect from the next period, with the fractional sequence restarted at k=1.
- R6: A setting loaded while idle is in force for the first period of the next run.
- R7: An integer part below 4 is treated as 4.
- R8: A denominator of 0 is treated as 1. A numerator greater than or equal to the denominator is treated as denominator minus one.
- R9: After reset, `tick` is low, the active setting is N=10 (parameter `RST_INT`), a=1, b=0, and no setting is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to produce ticks; low holds the divider idle |
| cfg_load | input | 1 | One-cycle strobe that captures the three setting fields |
| cfg_int | input | 8 | Integer part N of the ratio |
| cfg_num | input | 6 | Fraction numerator b |
| cfg_den | input | 6 | Fraction denominator a |
| tick | output | 1 | One-cycle enable at each period end |

## Verification
The bench measures the length of every period and compares it with the floor-difference rule. It uses several fractions, including 62/63. An accumulator that wraps at the wrong point, or that starts from a nonzero value, would put the long periods in the wrong places or give the wrong count within a window of a periods. A setting is loaded three cycles into a running period. A design that applies it at once would shorten that period, and one that keeps the accumulator would start the new sequence out of phase. The bench also drives N below the minimum, a zero denominator and a numerator larger than the denominator. A design without the forcing rules would produce ticks too fast, divide by zero, or never settle on a bounded ratio.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    parameter int INT_W  = 8;
    parameter int FRAC_W = 6;
    localparam logic [INT_W-1:0]  MIN_INT = INT_W'(4);
    localparam logic [FRAC_W-1:0] ONE_DEN = FRAC_W'(1);

    typedef struct packed {
        logic [INT_W-1:0]  int_part;
        logic [FRAC_W-1:0] den;
        logic [FRAC_W-1:0] num;
    } div_cfg_t;

    // Force a raw setting into the legal range.
    function automatic div_cfg_t make_cfg(input logic [INT_W-1:0]  n,
                                          input logic [FRAC_W-1:0] b,
                                          input logic [FRAC_W-1:0] a);
        div_cfg_t c;
        c.int_part = (n < MIN_INT) ? MIN_INT : n;
        c.den      = (a == '0) ? ONE_DEN : a;
        c.num      = (b >= c.den) ? c.den - ONE_DEN : b;
        return c;
    endfunction

endpackage

// File: rtl/fdiv_cfg_hold.sv
module fdiv_cfg_hold
    import frac_div_pkg::*;
#(
    parameter int RST_INT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [INT_W-1:0]  raw_int,
    input  logic [FRAC_W-1:0] raw_num,
    input  logic [FRAC_W-1:0] raw_den,
    input  logic              run,
    input  logic              boundary,
    output div_cfg_t          act,
    output logic              apply
);
    localparam div_cfg_t RST_CFG = '{int_part: INT_W'(RST_INT), den: ONE_DEN, num: '0};

    div_cfg_t pend;
    logic     pend_v;

    assign apply = pend_v && (!run || boundary);

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= RST_CFG;
            pend   <= RST_CFG;
            pend_v <= 1'b0;
        end else begin
            if (apply)
                act <= pend;
            if (load) begin
                pend   <= make_cfg(raw_int, raw_num, raw_den);
                pend_v <= 1'b1;
            end else if (apply) begin
                pend_v <= 1'b0;
            end
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !boundary) |=> $stable(act)); // R5
    AST_INT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        act.int_part >= MIN_INT); // R7
    AST_FRAC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (act.den != '0) && (act.num < act.den)); // R8
endmodule

// File: rtl/fdiv_frac_acc.sv
module fdiv_frac_acc
    import frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              apply,
    input  logic              boundary,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    output logic              long_period
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    // The current period is long when adding b would reach the denominator.
    assign sum         = {1'b0, acc} + {1'b0, num};
    assign long_period = (sum >= {1'b0, den});

    always_ff @(posedge clk) begin
        if (rst || !run || apply)
            acc <= '0;
        else if (boundary)
            acc <= long_period ? FRAC_W'(sum - {1'b0, den}) : sum[FRAC_W-1:0];
    end

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
        acc < den); // R3
endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt
    import frac_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [INT_W-1:0] int_part,
    input  logic             long_period,
    output logic             boundary,
    output logic             tick
);
    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last     = {1'b0, int_part} - CNT_W'(1) + {{INT_W{1'b0}}, long_period};
    assign boundary = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= boundary;
            cnt  <= (!run || boundary) ? '0 : cnt + CNT_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= {1'b0, int_part}); // R3
    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick); // R4
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
    import frac_div_pkg::*;
#(
    parameter int RST_INT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_load,
    input  logic [INT_W-1:0]  cfg_int,
    input  logic [FRAC_W-1:0] cfg_num,
    input  logic [FRAC_W-1:0] cfg_den,
    output logic              tick
);
    div_cfg_t act;
    logic     apply;
    logic     boundary;
    logic     long_period;

    fdiv_cfg_hold #(.RST_INT(RST_INT)) u_cfg (
        .clk(clk), .rst(rst), .load(cfg_load),
        .raw_int(cfg_int), .raw_num(cfg_num), .raw_den(cfg_den),
        .run(run), .boundary(boundary), .act(act), .apply(apply)
    );

    fdiv_frac_acc u_acc (
        .clk(clk), .rst(rst), .run(run), .apply(apply), .boundary(boundary),
        .num(act.num), .den(act.den), .long_period(long_period)
    );

    fdiv_period_cnt u_cnt (
        .clk(clk), .rst(rst), .run(run), .int_part(act.int_part),
        .long_period(long_period), .boundary(boundary), .tick(tick)
    );
endmodule

// File: tb/frac_tick_div_bench.sv
`timescale 1ns/1ps
module frac_tick_div_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] cfg_int = 8'd10;
    logic [5:0] cfg_num = 6'd0;
    logic [5:0] cfg_den = 6'd1;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int lens[0:63];

    frac_tick_div u_frac_tick_div (
        .clk(clk), .rst(rst), .run(run), .cfg_load(cfg_load),
        .cfg_int(cfg_int), .cfg_num(cfg_num), .cfg_den(cfg_den), .tick(tick)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_idle(input int n, input int b, input int a);
        @(negedge clk);
        cfg_int = 8'(n); cfg_num = 6'(b); cfg_den = 6'(a); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        @(negedge clk);
    endtask

    // Run for nper periods and record the length of each one; optionally
    // load a new setting at edge index load_at.
    task automatic collect(input int nper, input int load_at,
                           input int ln, input int lb, input int la);
        int idx = 0;
        int last = 0;
        int got = 0;
        bit prev = 1'b0;
        bit dbl = 1'b0;
        @(negedge clk);
        run = 1'b1;
        while (got < nper && idx < nper * 300 + 50) begin
            @(posedge clk); #1;
            idx++;
            if (tick) begin
                if (prev) dbl = 1'b1;
                lens[got] = idx - last;
                last = idx;
                got++;
            end
            prev = tick;
            if (idx == load_at) begin
                cfg_int = 8'(ln); cfg_num = 6'(lb); cfg_den = 6'(la); cfg_load = 1'b1;
            end else if (idx == load_at + 1) begin
                cfg_load = 1'b0;
            end
        end
        run = 1'b0;
        check(got == nper, "R4 ticks produced", got, nper);
        check(!dbl, "R1 single-cycle tick", int'(dbl), 0);
        repeat (3) @(posedge clk);
    endtask

    function automatic int exp_len(input int n, input int b, input int a, input int k);
        return n + ((k * b) / a - ((k - 1) * b) / a);
    endfunction

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check(tick == 1'b0, "R9 tick low in reset", int'(tick), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(tick == 1'b0, "R9 tick low after reset", int'(tick), 0);
        collect(3, -1, 0, 0, 0);
        for (int i = 0; i < 3; i++)
            check(lens[i] == 10, "R9 R2 default period", lens[i], 10);
    endtask

    task automatic t_integer();
        load_idle(7, 0, 1);
        collect(5, -1, 0, 0, 0);
        check(lens[0] == 7, "R6 idle load in force at start", lens[0], 7);
        for (int i = 1; i < 5; i++)
            check(lens[i] == 7, "R2 integer period", lens[i], 7);
    endtask

    task automatic t_fraction(input int n, input int b, input int a, input int nper);
        int longs = 0;
        load_idle(n, b, a);
        collect(nper, -1, 0, 0, 0);
        for (int k = 1; k <= nper; k++) begin
            check(lens[k-1] == exp_len(n, b, a, k), "R3 period length",
                  lens[k-1], exp_len(n, b, a, k));
            if (k <= a && lens[k-1] == n + 1) longs++;
        end
        check(longs == b, "R3 long periods per window", longs, b);
    endtask

    task automatic t_idle();
        bit seen = 1'b0;
        run = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (tick) seen = 1'b1;
        end
        check(!seen, "R4 no tick while idle", int'(seen), 0);
    endtask

    task automatic t_clamp();
        load_idle(2, 0, 1);
        collect(3, -1, 0, 0, 0);
        for (int i = 0; i < 3; i++)
            check(lens[i] == 4, "R7 integer floor", lens[i], 4);
        load_idle(6, 5, 0);
        collect(4, -1, 0, 0, 0);
        for (int i = 0; i < 4; i++)
            check(lens[i] == 6, "R8 zero denominator", lens[i], 6);
        load_idle(5, 9, 4);
        collect(8, -1, 0, 0, 0);
        for (int k = 1; k <= 8; k++)
            check(lens[k-1] == exp_len(5, 3, 4, k), "R8 numerator limited",
                  lens[k-1], exp_len(5, 3, 4, k));
    endtask

    task automatic t_midload();
        int exp_l[6] = '{10, 10, 5, 6, 5, 6};
        load_idle(10, 0, 1);
        collect(6, 13, 5, 1, 2);
        for (int i = 0; i < 6; i++)
            check(lens[i] == exp_l[i], "R5 load at period boundary", lens[i], exp_l[i]);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_idle();
        t_fraction(5, 1, 3, 9);
        t_fraction(6, 3, 7, 14);
        t_fraction(4, 62, 63, 63);
        t_clamp();
        t_midload();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule